// File: doc/BRIEF.md
# Size-Switchable Eight-Point / Dual Four-Point Integer Transform

This block is a pipelined one-dimensional integer transform engine. Each valid cycle it takes a vector of eight signed samples and returns eight signed coefficients. A per-vector size bit sets how the vector is read. In wide mode the vector is one eight-point block. A folding stage forms the pairwise sums and differences of mirrored samples. One four-point kernel then turns the sums into the even coefficients, and a second four-point kernel turns the differences into the odd coefficients. This gives an approximate eight-point transform.

In narrow mode the folding stage is bypassed. The same two kernels then work as two independent four-point transforms, one on each half of the vector. An output stage interleaves the two kernel results in wide mode and places them side by side in narrow mode.

The size bit travels down the pipeline with its vector, so wide and narrow vectors can be mixed freely at full rate. The block applies no normalising shift and gives full-precision results. Scaling and any row/column sequencing are left to the surrounding logic.

Top module: `xform8_dual4`

## Requirements
- R1: After reset, and before any valid input, `out_valid` is 0 and every output coefficient is 0.
- R2: `out_valid` rises exactly three clock cycles after the cycle in which `in_valid` is sampled high, one result per input vector, in input order.
- R3: The four-point kernel K maps u0..u3 to k0..k3. Let s0=u0+u3, s1=u1+u2, d0=u0-u3 and d1=u1-u2. Then k0=64(s0+s1), k1=83·d0+36·d1, k2=64(s0-s1) and k3=36·d0-83·d1. With `in_sel8`=1, output coefficients 0, 2, 4 and 6 are K applied to a(i)=x(i)+x(7-i), for i=0..3.
- R4: With `in_sel8`=1, output coefficients 1, 3, 5 and 7 are K applied to b(i)=x(i)-x(7-i), for i=0..3.
- R5: With `in_sel8`=0, output coefficients 0..3 are K applied to samples 0..3, in natural order.
- R6: With `in_sel8`=0, output coefficients 4..7 are K applied to samples 4..7 and do not depend on samples 0..3.
- R7: The size bit is captured with each vector. Consecutive vectors with alternating size bits are each transformed in their own mode, with no bubble.
- R8: Sample i occupies `in_data[16i+15:16i]` and coefficient k occupies `out_data[26k+25:26k]`, both two's complement. Full-scale inputs (-32768 and 32767) give exact results with no wrap.
- R9: While `in_valid` is low, input data is ignored. Output coefficients keep the value of the last result until the next valid vector reaches the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously inside the block |
| in_valid | input | 1 | Input vector valid |
| in_sel8 | input | 1 | Size select for this vector: 1 = one eight-point transform, 0 = two four-point transforms |
| in_data | input | 128 | Eight signed 16-bit samples, sample i in bits 16i+15:16i |
| out_valid | output | 1 | Output vector valid |
| out_data | output | 208 | Eight signed 26-bit coefficients, coefficient k in bits 26k+25:26k |

## Verification
A unit impulse at each end of the vector tells the even and odd kernel paths apart and exposes a wrong mirror pairing in the folding stage. Ramps and alternating-sign vectors give nonzero results on every coefficient, which shows whether the output interleave and the narrow-mode half placement are right. In narrow mode, one half is kept constant while the other half changes, so any leakage across halves shows up in the fixed half. Full-scale vectors check for silent wrap. A stream that toggles the size bit on every vector, followed by pseudo-random vectors, checks that the mode is tied to each vector. Garbage data driven while `in_valid` is low shows whether the outputs hold their last value.

// File: rtl/xf_pkg.sv
package xf_pkg;
  localparam int LANES   = 8;
  localparam int HALF    = LANES / 2;
  localparam int NKERN   = 2;
  // growth of the kernel: two butterfly levels plus a 7-bit coefficient
  localparam int KGROW   = 9;
  // folding stage adds one bit
  localparam int FGROW   = 1;
  localparam int GROWTH  = KGROW + FGROW;
  localparam int SH_DC   = 6;   // 64 = 1 << 6
  localparam int PIPE    = 3;   // register stages from input to output
endpackage

// File: rtl/xf_input_stage.sv
module xf_input_stage
  import xf_pkg::*;
#(
  parameter int DW = 16,
  localparam int KW = DW + FGROW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 vi,
  input  logic                 sel8_i,
  input  logic signed [DW-1:0] x [LANES],
  output logic                 vo,
  output logic                 sel8_o,
  output logic signed [KW-1:0] kin [NKERN][HALF]
);

  logic signed [KW-1:0] kin_nxt [NKERN][HALF];
  logic signed [KW-1:0] xe [LANES];

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      xe[i] = KW'($signed(x[i]));
    end
    for (int i = 0; i < HALF; i++) begin
      if (sel8_i) begin
        kin_nxt[0][i] = xe[i] + xe[LANES-1-i];
        kin_nxt[1][i] = xe[i] - xe[LANES-1-i];
      end else begin
        kin_nxt[0][i] = xe[i];
        kin_nxt[1][i] = xe[HALF+i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vo     <= 1'b0;
      sel8_o <= 1'b0;
      for (int g = 0; g < NKERN; g++) begin
        for (int i = 0; i < HALF; i++) begin
          kin[g][i] <= '0;
        end
      end
    end else begin
      vo <= vi;
      if (vi) begin
        sel8_o <= sel8_i;
        for (int g = 0; g < NKERN; g++) begin
          for (int i = 0; i < HALF; i++) begin
            kin[g][i] <= kin_nxt[g][i];
          end
        end
      end
    end
  end

  // R3 / R4: the even and odd operands of a pair add back to twice the sample
  a_r3_fold_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (vo && sel8_o) |->
      (KW'(kin[0][0] + kin[1][0]) == KW'($signed({$past(x[0]), 1'b0}))));

  // R6: in narrow mode the second kernel sees the upper half unchanged
  a_r6_half_route: assert property (@(posedge clk) disable iff (!rst_n)
    (vo && !sel8_o) |-> (kin[1][HALF-1] == KW'($signed($past(x[LANES-1])))));

endmodule

// File: rtl/xf_kernel4.sv
module xf_kernel4
  import xf_pkg::*;
#(
  parameter int IW = 17,
  localparam int OW = IW + KGROW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 vi,
  input  logic signed [IW-1:0] u [HALF],
  output logic                 vo,
  output logic signed [OW-1:0] k [HALF]
);

  logic signed [OW-1:0] e [HALF];
  logic signed [OW-1:0] s0, s1, d0, d1;
  logic signed [OW-1:0] k_nxt [HALF];

  function automatic logic signed [OW-1:0] mul83(input logic signed [OW-1:0] v);
    return (v <<< 6) + (v <<< 4) + (v <<< 1) + v;
  endfunction

  function automatic logic signed [OW-1:0] mul36(input logic signed [OW-1:0] v);
    return (v <<< 5) + (v <<< 2);
  endfunction

  always_comb begin
    for (int i = 0; i < HALF; i++) begin
      e[i] = OW'($signed(u[i]));
    end
    s0 = e[0] + e[3];
    s1 = e[1] + e[2];
    d0 = e[0] - e[3];
    d1 = e[1] - e[2];
    k_nxt[0] = (s0 + s1) <<< SH_DC;
    k_nxt[2] = (s0 - s1) <<< SH_DC;
    k_nxt[1] = mul83(d0) + mul36(d1);
    k_nxt[3] = mul36(d0) - mul83(d1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vo <= 1'b0;
      for (int i = 0; i < HALF; i++) begin
        k[i] <= '0;
      end
    end else begin
      vo <= vi;
      if (vi) begin
        for (int i = 0; i < HALF; i++) begin
          k[i] <= k_nxt[i];
        end
      end
    end
  end

  // R3: the first coefficient is the plain sum of the operands, scaled by 64
  a_r3_dc_gain: assert property (@(posedge clk) disable iff (!rst_n)
    vo |-> (k[0] == ($past(OW'($signed(u[0])) + OW'($signed(u[1]))
                         + OW'($signed(u[2])) + OW'($signed(u[3]))) <<< SH_DC)));

  // R3: the third coefficient weighs outer operands +64 and inner ones -64
  a_r3_mid_gain: assert property (@(posedge clk) disable iff (!rst_n)
    vo |-> (k[2] == ($past(OW'($signed(u[0])) - OW'($signed(u[1]))
                         - OW'($signed(u[2])) + OW'($signed(u[3]))) <<< SH_DC)));

endmodule

// File: rtl/xf_output_order.sv
module xf_output_order
  import xf_pkg::*;
#(
  parameter int CW = 26
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 vi,
  input  logic                 sel8_i,
  input  logic signed [CW-1:0] ev [HALF],
  input  logic signed [CW-1:0] od [HALF],
  output logic                 vo,
  output logic signed [CW-1:0] y [LANES]
);

  logic signed [CW-1:0] y_nxt [LANES];

  always_comb begin
    for (int i = 0; i < HALF; i++) begin
      if (sel8_i) begin
        y_nxt[2*i]   = ev[i];
        y_nxt[2*i+1] = od[i];
      end else begin
        y_nxt[i]      = ev[i];
        y_nxt[HALF+i] = od[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vo <= 1'b0;
      for (int i = 0; i < LANES; i++) begin
        y[i] <= '0;
      end
    end else begin
      vo <= vi;
      if (vi) begin
        for (int i = 0; i < LANES; i++) begin
          y[i] <= y_nxt[i];
        end
      end
    end
  end

  // R9: with no result arriving, every output lane holds its value
  for (genvar gk = 0; gk < LANES; gk++) begin : g_hold
    a_r9_hold_lane: assert property (@(posedge clk) disable iff (!rst_n)
      !vi |=> $stable(y[gk]));
  end

endmodule

// File: rtl/xform8_dual4.sv
module xform8_dual4
  import xf_pkg::*;
#(
  parameter int DW = 16,
  localparam int OW = DW + GROWTH
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic                  in_sel8,
  input  logic [LANES*DW-1:0]   in_data,
  output logic                  out_valid,
  output logic [LANES*OW-1:0]   out_data
);

  localparam int KW = DW + FGROW;

  // reset: asserted at once, released on the clock
  logic rst_s1, rst_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  logic signed [DW-1:0] x [LANES];
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      x[i] = in_data[i*DW +: DW];
    end
  end

  logic                 st1_v, st1_sel;
  logic signed [KW-1:0] kin [NKERN][HALF];

  xf_input_stage #(.DW(DW)) u_fold (
    .clk    (clk),
    .rst_n  (rst_s2),
    .vi     (in_valid),
    .sel8_i (in_sel8),
    .x      (x),
    .vo     (st1_v),
    .sel8_o (st1_sel),
    .kin    (kin)
  );

  logic                 kv   [NKERN];
  logic signed [OW-1:0] kout [NKERN][HALF];

  for (genvar g = 0; g < NKERN; g++) begin : g_kern
    xf_kernel4 #(.IW(KW)) u_k4 (
      .clk   (clk),
      .rst_n (rst_s2),
      .vi    (st1_v),
      .u     (kin[g]),
      .vo    (kv[g]),
      .k     (kout[g])
    );
  end

  // size bit follows its vector through the kernel stage
  logic st2_sel_nxt, st2_sel;
  always_comb begin
    st2_sel_nxt = st1_v ? st1_sel : st2_sel;
  end
  always_ff @(posedge clk or negedge rst_s2) begin
    if (!rst_s2) st2_sel <= 1'b0;
    else         st2_sel <= st2_sel_nxt;
  end

  logic                 o_v;
  logic signed [OW-1:0] y [LANES];

  xf_output_order #(.CW(OW)) u_order (
    .clk    (clk),
    .rst_n  (rst_s2),
    .vi     (kv[0]),
    .sel8_i (st2_sel),
    .ev     (kout[0]),
    .od     (kout[1]),
    .vo     (o_v),
    .y      (y)
  );

  always_comb begin
    out_valid = o_v;
    for (int i = 0; i < LANES; i++) begin
      out_data[i*OW +: OW] = y[i];
    end
  end

  // R2: one result per input, three cycles later
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_s2)
    out_valid == $past(in_valid, PIPE));

  // R2: both kernels advance in lock step
  a_r2_kernels_aligned: assert property (@(posedge clk) disable iff (!rst_s2)
    kv[0] == kv[1]);

endmodule

// File: tb/xform8_dual4_bench.sv
module xform8_dual4_bench;
  localparam int DW = 16;
  localparam int OW = DW + 10;
  localparam int N  = 8;

  logic            clk;
  logic            rst_n;
  logic            in_valid;
  logic            in_sel8;
  logic [N*DW-1:0] in_data;
  logic            out_valid;
  logic [N*OW-1:0] out_data;

  xform8_dual4 #(.DW(DW)) u_xform8_dual4 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sel8(in_sel8),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct {
    int y [8];
    bit sel;
    bit alt;
    int cyc;
  } exp_t;

  exp_t exp_q [$];
  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  bit   mon_en = 1'b0;
  bit   done = 1'b0;
  int   last [8];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic void kern(input int u0, u1, u2, u3, output int k [4]);
    int s0, s1, d0, d1;
    s0 = u0 + u3; s1 = u1 + u2; d0 = u0 - u3; d1 = u1 - u2;
    k[0] = 64 * (s0 + s1);
    k[1] = 83 * d0 + 36 * d1;
    k[2] = 64 * (s0 - s1);
    k[3] = 36 * d0 - 83 * d1;
  endfunction

  function automatic int outv(input int k);
    return int'($signed(out_data[k*OW +: OW]));
  endfunction

  task automatic report(input bit ok, input string req, input string what,
                        input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic drive(input int x [8], input bit s, input bit alt);
    exp_t e;
    int ka [4];
    int kb [4];
    @(posedge clk); #1;
    in_valid = 1'b1;
    in_sel8  = s;
    for (int i = 0; i < 8; i++) in_data[i*DW +: DW] = x[i][DW-1:0];
    if (s) begin
      kern(x[0]+x[7], x[1]+x[6], x[2]+x[5], x[3]+x[4], ka);
      kern(x[0]-x[7], x[1]-x[6], x[2]-x[5], x[3]-x[4], kb);
      for (int i = 0; i < 4; i++) begin
        e.y[2*i] = ka[i]; e.y[2*i+1] = kb[i];
      end
    end else begin
      kern(x[0], x[1], x[2], x[3], ka);
      kern(x[4], x[5], x[6], x[7], kb);
      for (int i = 0; i < 4; i++) begin
        e.y[i] = ka[i]; e.y[4+i] = kb[i];
      end
    end
    e.sel = s; e.alt = alt; e.cyc = cyc;
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int c = 0; c < n; c++) begin
      @(posedge clk); #1;
      in_valid = 1'b0;
      in_sel8  = c[0];
      in_data  = {4{32'hDEAD_BEEF}};
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_en) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          report(1'b0, "R2", "unexpected out_valid", 1, 0);
        end else begin
          exp_t e;
          bit ok_a, ok_b;
          int bad_a, bad_b, exp_a, exp_b;
          e = exp_q.pop_front();
          report(cyc - e.cyc == 3, "R2", "latency", cyc - e.cyc, 3);
          ok_a = 1'b1; ok_b = 1'b1; bad_a = 0; bad_b = 0; exp_a = 0; exp_b = 0;
          for (int k = 0; k < 8; k++) begin
            bit grp_b;
            grp_b = e.sel ? k[0] : (k >= 4);
            if (outv(k) != e.y[k]) begin
              if (grp_b) begin
                if (ok_b) begin bad_b = outv(k); exp_b = e.y[k]; end
                ok_b = 1'b0;
              end else begin
                if (ok_a) begin bad_a = outv(k); exp_a = e.y[k]; end
                ok_a = 1'b0;
              end
            end
            last[k] = outv(k);
          end
          if (e.sel) begin
            report(ok_a, "R3", "even coefficient", bad_a, exp_a);
            report(ok_b, "R4", "odd coefficient", bad_b, exp_b);
          end else begin
            report(ok_a, "R5", "low-half coefficient", bad_a, exp_a);
            report(ok_b, "R6", "high-half coefficient", bad_b, exp_b);
          end
          if (e.alt)
            report(ok_a && ok_b, "R7", "mode switch vector",
                   ok_a ? bad_b : bad_a, ok_a ? exp_b : exp_a);
        end
      end else begin
        bit ok;
        int a, x;
        ok = 1'b1; a = 0; x = 0;
        for (int k = 0; k < 8; k++)
          if (outv(k) != last[k]) begin
            if (ok) begin a = outv(k); x = last[k]; end
            ok = 1'b0;
          end
        report(ok, "R9", "output hold while idle", a, x);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL R2 watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int v [8];
    rst_n = 1'b0; in_valid = 1'b0; in_sel8 = 1'b0; in_data = '0;
    for (int k = 0; k < 8; k++) last[k] = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1: reset state
    report(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    report(out_data == '0, "R1", "out_data after reset", outv(0), 0);
    mon_en = 1'b1;

    // zero vector, both modes
    v = '{0,0,0,0,0,0,0,0};
    drive(v, 1'b1, 1'b0); drive(v, 1'b0, 1'b0);
    // impulses at each end (R3, R4: mirror pairing)
    v = '{1,0,0,0,0,0,0,0}; drive(v, 1'b1, 1'b0);
    v = '{0,0,0,0,0,0,0,1}; drive(v, 1'b1, 1'b0);
    // ramp and alternating signs
    v = '{1,2,3,4,5,6,7,8}; drive(v, 1'b1, 1'b0); drive(v, 1'b0, 1'b0);
    v = '{100,-100,100,-100,100,-100,100,-100};
    drive(v, 1'b1, 1'b0); drive(v, 1'b0, 1'b0);
    idle(5);
    // R6: upper half independent of lower half
    v = '{9,-3,7,1,11,-5,2,4};   drive(v, 1'b0, 1'b0);
    v = '{-800,55,31,-2,11,-5,2,4}; drive(v, 1'b0, 1'b0);
    // R8: full-scale values
    v = '{32767,32767,32767,32767,32767,32767,32767,32767}; drive(v, 1'b1, 1'b0);
    v = '{-32768,-32768,-32768,-32768,-32768,-32768,-32768,-32768}; drive(v, 1'b1, 1'b0);
    v = '{32767,-32768,32767,-32768,-32768,32767,-32768,32767};
    drive(v, 1'b1, 1'b0); drive(v, 1'b0, 1'b0);
    v = '{32767,32767,-32768,-32768,-32768,-32768,32767,32767}; drive(v, 1'b0, 1'b0);
    idle(4);
    // R7: size bit toggles every vector, back to back
    for (int n = 0; n < 12; n++) begin
      for (int k = 0; k < 8; k++) v[k] = (n * 37 + k * 113) % 2001 - 1000;
      drive(v, n[0], 1'b1);
    end
    idle(3);
    // pseudo-random traffic with gaps
    for (int n = 0; n < 60; n++) begin
      for (int k = 0; k < 8; k++) v[k] = int'($signed(16'($urandom())));
      drive(v, 1'($urandom()), 1'b0);
      if (n % 7 == 3) idle(2);
    end
    idle(8);
    report(exp_q.size() == 0, "R2", "results outstanding", exp_q.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule